// File: doc/BRIEF.md
# Indirect Register Access Sequencer

This block drives a peripheral that offers only two 16-bit ports on its bus: one that takes a register index and one that carries register data. An internal client issues single register reads or writes, each 16 or 32 bits wide, through a request/acknowledge interface. The sequencer turns each request into a timed series of bus cycles. First it writes the index to the index port. Then it runs one or two cycles on the data port.

The peripheral needs minimum quiet times between cycles. These minimums are given in nanoseconds and converted to whole clock cycles from a clock-period parameter, always rounding up. During a quiet time the read and write strobes stay deasserted. A 32-bit value crosses the bus as two 16-bit halves, low half first. When a read completes, the assembled value is returned with a one-cycle acknowledge.

Top module: `indirSeq`

## Requirements
- R1: After reset the block is idle: chip select, read strobe and write strobe are all high (deasserted), the data bus output enable is low, and busy and ack are low.
- R2: Every access starts with one write cycle on the index port (busAddrSel = 1). For a write request the word driven is the 8-bit index with bit 7 forced to 1. For a read request it is the plain index. Bits 15:8 of the word are zero.
- R3: A 32-bit write places wdata[15:0] on the first data-port write cycle and wdata[31:16] on the second.
- R4: A 32-bit read puts the bus value of the first data-port read cycle into rdata[15:0] and the value of the second into rdata[31:16].
- R5: A 16-bit access makes exactly one data-port cycle. A 16-bit write sends wdata[15:0]. A 16-bit read returns the bus value in rdata[15:0], with rdata[31:16] zero.
- R6: The number of cycles with both strobes high between the index-port cycle and the first data-port cycle is ceil(ADDR_GAP_NS / CLK_PERIOD_NS).
- R7: The number of cycles with both strobes high between the two data-port cycles of a 32-bit access is ceil(DATA_GAP_NS / CLK_PERIOD_NS).
- R8: Each bus cycle holds its strobe low for exactly STROBE_CYC clock cycles. Chip select is low exactly while a strobe is low. Read and write strobes are never low together.
- R9: The output enable is high during every write strobe and low during every read strobe. Read data is captured on the last clock edge of the read strobe.
- R10: A request is accepted only while busy is low. Busy stays high from acceptance through the ack cycle. Ack is a single-cycle pulse. A request raised while busy is ignored and produces no extra bus cycles.
- R11: From the clock edge that accepts a request, ack rises after 1 + 2·STROBE_CYC + addrGap + dataGap cycles for a 16-bit access, plus dataGap + STROBE_CYC more for a 32-bit access. Here addrGap and dataGap are the rounded gaps of R6 and R7. A trailing data gap follows the last data cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request, sampled while idle |
| we | input | 1 | 1 = write, 0 = read |
| size32 | input | 1 | 1 = 32-bit access, 0 = 16-bit |
| index | input | IDX_W | Register index |
| wdata | input | 2*BUS_W | Write data |
| busy | output | 1 | Access in progress |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | 2*BUS_W | Read result, valid with ack on reads |
| busCsN | output | 1 | Chip select, active low |
| busRdN | output | 1 | Read strobe, active low |
| busWrN | output | 1 | Write strobe, active low |
| busAddrSel | output | 1 | 1 = index port, 0 = data port |
| busOe | output | 1 | Drive enable for busDout |
| busDout | output | BUS_W | Bus write data |
| busDin | input | BUS_W | Bus read data |

## Verification
The bench sweeps all four combinations of direction and width over indices spread across the range, including those with bit 7 already set. A design that forgot the write flag, or set it on reads, produces a wrong index-port word. The bench returns a distinct value for each data read, so half-word order is checked in both directions. A swapped split would show as exchanged halves in rdata or on the bus. It times every strobe width and every gap, and the full latency to ack. An off-by-one in a counter, a gap rounded down, or a missing trailing gap changes those counts. Requests pulsed mid-access check that a design which re-accepts while busy shows up as extra bus cycles.

// File: rtl/indirSeqPkg.sv
package indirSeqPkg;

  typedef enum logic [2:0] {
    sIdle, sAdrStb, sAdrGap, sLoStb, sMidGap, sHiStb, sTailGap, sDone
  } seqState_t;

  typedef enum logic [1:0] {
    wAddr, wLo, wHi
  } wordSel_t;

  typedef struct packed {
    logic     csOn;
    logic     rdOn;
    logic     wrOn;
    logic     addrPort;
    logic     drive;
    wordSel_t word;
    logic     load;
    logic     capLo;
    logic     capHi;
  } seqCtl_t;

  // whole cycles covering a nanosecond minimum, never below one
  function automatic int cyclesFor(input int ns, input int periodNs);
    int c;
    c = (ns + periodNs - 1) / periodNs;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/indirSeqCtrl.sv
module indirSeqCtrl
  import indirSeqPkg::*;
#(
  parameter int STROBE_CYC   = 3,
  parameter int ADDR_GAP_CYC = 30,
  parameter int DATA_GAP_CYC = 15
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    req,
  input  logic    we,
  input  logic    size32,
  output logic    busy,
  output logic    ack,
  output seqCtl_t ctl
);

  localparam int MAX_A = (STROBE_CYC > ADDR_GAP_CYC) ? STROBE_CYC : ADDR_GAP_CYC;
  localparam int MAX_L = (MAX_A > DATA_GAP_CYC) ? MAX_A : DATA_GAP_CYC;
  localparam int CW    = $clog2(MAX_L + 1);

  seqState_t state, nxtState;
  logic [CW-1:0] cnt;
  logic [CW-1:0] limit;
  logic weQ, s32Q, lastCyc, strobeState;

  always_comb begin
    unique case (state)
      sAdrStb, sLoStb, sHiStb: limit = CW'(STROBE_CYC);
      sAdrGap:                 limit = CW'(ADDR_GAP_CYC);
      sMidGap, sTailGap:       limit = CW'(DATA_GAP_CYC);
      default:                 limit = CW'(1);
    endcase
  end

  assign lastCyc = (cnt == limit - CW'(1));

  always_comb begin
    unique case (state)
      sAdrStb:  nxtState = sAdrGap;
      sAdrGap:  nxtState = sLoStb;
      sLoStb:   nxtState = s32Q ? sMidGap : sTailGap;
      sMidGap:  nxtState = sHiStb;
      sHiStb:   nxtState = sTailGap;
      sTailGap: nxtState = sDone;
      default:  nxtState = sIdle;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= sIdle;
      cnt   <= '0;
      weQ   <= 1'b0;
      s32Q  <= 1'b0;
    end else if (state == sIdle) begin
      cnt <= '0;
      if (req) begin
        weQ   <= we;
        s32Q  <= size32;
        state <= sAdrStb;
      end
    end else if (lastCyc) begin
      state <= nxtState;
      cnt   <= '0;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end

  assign strobeState = (state == sAdrStb) || (state == sLoStb) || (state == sHiStb);

  always_comb begin
    ctl          = '0;
    ctl.word     = wAddr;
    ctl.load     = (state == sIdle) && req;
    ctl.csOn     = strobeState;
    ctl.addrPort = (state == sAdrStb);
    ctl.wrOn     = strobeState && ((state == sAdrStb) || weQ);
    ctl.rdOn     = strobeState && (state != sAdrStb) && !weQ;
    ctl.drive    = ctl.wrOn;
    if (state == sLoStb) ctl.word = wLo;
    if (state == sHiStb) ctl.word = wHi;
    ctl.capLo    = (state == sLoStb) && !weQ && lastCyc;
    ctl.capHi    = (state == sHiStb) && !weQ && lastCyc;
  end

  assign busy = (state != sIdle);
  assign ack  = (state == sDone);

endmodule

// File: rtl/indirSeqData.sv
module indirSeqData
  import indirSeqPkg::*;
#(
  parameter int BUS_W  = 16,
  parameter int IDX_W  = 8,
  parameter int WR_BIT = 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  seqCtl_t            ctl,
  input  logic               we,
  input  logic [IDX_W-1:0]   index,
  input  logic [2*BUS_W-1:0] wdata,
  input  logic [BUS_W-1:0]   busDin,
  output logic [2*BUS_W-1:0] rdata,
  output logic               busCsN,
  output logic               busRdN,
  output logic               busWrN,
  output logic               busAddrSel,
  output logic               busOe,
  output logic [BUS_W-1:0]   busDout
);

  localparam int WORD_W = 2 * BUS_W;

  logic [IDX_W-1:0]  idxQ;
  logic              weQ;
  logic [WORD_W-1:0] wdataQ;
  logic [WORD_W-1:0] rdataQ;
  logic [BUS_W-1:0]  addrWord;
  logic [BUS_W-1:0]  muxWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idxQ   <= '0;
      weQ    <= 1'b0;
      wdataQ <= '0;
      rdataQ <= '0;
    end else begin
      if (ctl.load) begin
        idxQ   <= index;
        weQ    <= we;
        wdataQ <= wdata;
        rdataQ <= '0;
      end
      if (ctl.capLo) rdataQ[BUS_W-1:0]      <= busDin;
      if (ctl.capHi) rdataQ[WORD_W-1:BUS_W] <= busDin;
    end
  end

  always_comb begin
    addrWord = '0;
    addrWord[IDX_W-1:0] = idxQ;
    if (weQ) addrWord[WR_BIT] = 1'b1;
  end

  always_comb begin
    unique case (ctl.word)
      wLo:     muxWord = wdataQ[BUS_W-1:0];
      wHi:     muxWord = wdataQ[WORD_W-1:BUS_W];
      default: muxWord = addrWord;
    endcase
  end

  assign busDout    = ctl.drive ? muxWord : '0;
  assign busOe      = ctl.drive;
  assign busCsN     = !ctl.csOn;
  assign busRdN     = !ctl.rdOn;
  assign busWrN     = !ctl.wrOn;
  assign busAddrSel = ctl.addrPort;
  assign rdata      = rdataQ;

endmodule

// File: rtl/indirSeq.sv
module indirSeq
  import indirSeqPkg::*;
#(
  parameter int BUS_W         = 16,
  parameter int IDX_W         = 8,
  parameter int WR_BIT        = 7,
  parameter int CLK_PERIOD_NS = 10,
  parameter int ADDR_GAP_NS   = 300,
  parameter int DATA_GAP_NS   = 150,
  parameter int STROBE_CYC    = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               req,
  input  logic               we,
  input  logic               size32,
  input  logic [IDX_W-1:0]   index,
  input  logic [2*BUS_W-1:0] wdata,
  output logic               busy,
  output logic               ack,
  output logic [2*BUS_W-1:0] rdata,
  output logic               busCsN,
  output logic               busRdN,
  output logic               busWrN,
  output logic               busAddrSel,
  output logic               busOe,
  output logic [BUS_W-1:0]   busDout,
  input  logic [BUS_W-1:0]   busDin
);

  localparam int ADDR_GAP_CYC = cyclesFor(ADDR_GAP_NS, CLK_PERIOD_NS);
  localparam int DATA_GAP_CYC = cyclesFor(DATA_GAP_NS, CLK_PERIOD_NS);

  seqCtl_t ctl;

  indirSeqCtrl #(
    .STROBE_CYC  (STROBE_CYC),
    .ADDR_GAP_CYC(ADDR_GAP_CYC),
    .DATA_GAP_CYC(DATA_GAP_CYC)
  ) uCtrl (
    .clk   (clk),
    .rstN  (rstN),
    .req   (req),
    .we    (we),
    .size32(size32),
    .busy  (busy),
    .ack   (ack),
    .ctl   (ctl)
  );

  indirSeqData #(
    .BUS_W (BUS_W),
    .IDX_W (IDX_W),
    .WR_BIT(WR_BIT)
  ) uData (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .we        (we),
    .index     (index),
    .wdata     (wdata),
    .busDin    (busDin),
    .rdata     (rdata),
    .busCsN    (busCsN),
    .busRdN    (busRdN),
    .busWrN    (busWrN),
    .busAddrSel(busAddrSel),
    .busOe     (busOe),
    .busDout   (busDout)
  );

endmodule

// File: rtl/indirSeqChecker.sv
module indirSeqChecker
  import indirSeqPkg::*;
#(
  parameter int CLK_PERIOD_NS = 10,
  parameter int ADDR_GAP_NS   = 300,
  parameter int DATA_GAP_NS   = 150,
  parameter int STROBE_CYC    = 3
) (
  input logic clk,
  input logic rstN,
  input logic busy,
  input logic ack,
  input logic busCsN,
  input logic busRdN,
  input logic busWrN,
  input logic busAddrSel,
  input logic busOe
);

  localparam int ADDR_GAP_CYC = cyclesFor(ADDR_GAP_NS, CLK_PERIOD_NS);
  localparam int DATA_GAP_CYC = cyclesFor(DATA_GAP_NS, CLK_PERIOD_NS);

  logic        strobeOn, prevOn, lastAddr;
  logic [15:0] idleCnt, onCnt;

  assign strobeOn = !busRdN || !busWrN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevOn   <= 1'b0;
      lastAddr <= 1'b0;
      idleCnt  <= 16'hFFFF;
      onCnt    <= '0;
    end else begin
      prevOn <= strobeOn;
      if (strobeOn) begin
        idleCnt  <= '0;
        lastAddr <= busAddrSel;
        onCnt    <= onCnt + 16'd1;
      end else begin
        onCnt <= '0;
        if (idleCnt != 16'hFFFF) idleCnt <= idleCnt + 16'd1;
      end
    end
  end

  a_r6_addr_gap: assert property (@(posedge clk) disable iff (!rstN)
    (strobeOn && !prevOn && !busAddrSel && lastAddr) |-> (idleCnt >= 16'(ADDR_GAP_CYC)));

  a_r7_data_gap: assert property (@(posedge clk) disable iff (!rstN)
    (strobeOn && !prevOn && !busAddrSel && !lastAddr) |-> (idleCnt >= 16'(DATA_GAP_CYC)));

  a_r8_strobe_width: assert property (@(posedge clk) disable iff (!rstN)
    (prevOn && !strobeOn) |-> (onCnt == 16'(STROBE_CYC)));

  a_r8_no_dual_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !(!busRdN && !busWrN));

  a_r8_cs_tracks: assert property (@(posedge clk) disable iff (!rstN)
    strobeOn == !busCsN);

  a_r2_index_write_only: assert property (@(posedge clk) disable iff (!rstN)
    (!busCsN && busAddrSel) |-> !busWrN);

  a_r9_read_no_drive: assert property (@(posedge clk) disable iff (!rstN)
    !busRdN |-> !busOe);

  a_r9_write_drive: assert property (@(posedge clk) disable iff (!rstN)
    !busWrN |-> busOe);

  a_r10_ack_pulse: assert property (@(posedge clk) disable iff (!rstN)
    ack |=> !ack);

  a_r10_ack_busy: assert property (@(posedge clk) disable iff (!rstN)
    ack |-> busy);

endmodule

bind indirSeq indirSeqChecker #(
  .CLK_PERIOD_NS(CLK_PERIOD_NS),
  .ADDR_GAP_NS  (ADDR_GAP_NS),
  .DATA_GAP_NS  (DATA_GAP_NS),
  .STROBE_CYC   (STROBE_CYC)
) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .busy      (busy),
  .ack       (ack),
  .busCsN    (busCsN),
  .busRdN    (busRdN),
  .busWrN    (busWrN),
  .busAddrSel(busAddrSel),
  .busOe     (busOe)
);

// File: tb/indirSeq_test.sv
module indirSeq_test;

  localparam int PER   = 10;
  localparam int ANS   = 300;
  localparam int DNS   = 150;
  localparam int SC    = 3;
  localparam int AGAP  = (ANS + PER - 1) / PER;
  localparam int DGAP  = (DNS + PER - 1) / PER;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic        size32 = 1'b0;
  logic [7:0]  index = '0;
  logic [31:0] wdata = '0;
  logic        busy, ack;
  logic [31:0] rdata;
  logic        busCsN, busRdN, busWrN, busAddrSel, busOe;
  logic [15:0] busDout;
  logic [15:0] busDin;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  indirSeq #(
    .CLK_PERIOD_NS(PER), .ADDR_GAP_NS(ANS), .DATA_GAP_NS(DNS), .STROBE_CYC(SC)
  ) uut (
    .clk(clk), .rstN(rstN), .req(req), .we(we), .size32(size32), .index(index),
    .wdata(wdata), .busy(busy), .ack(ack), .rdata(rdata), .busCsN(busCsN),
    .busRdN(busRdN), .busWrN(busWrN), .busAddrSel(busAddrSel), .busOe(busOe),
    .busDout(busDout), .busDin(busDin)
  );

  // bus monitor: event kind 0 = index write, 1 = data write, 2 = data read
  int          evKind[8];
  logic [15:0] evVal[8];
  int          evGap[8];
  int          evWidth[8];
  int          evCount = 0;
  int          idleRun = 0;
  int          onRun = 0;
  int          oeErr = 0;
  int          csErr = 0;
  int          readNum = 0;
  logic        prevOn = 1'b0;
  logic [7:0]  curIdx = '0;

  function automatic logic [15:0] pat(input logic [7:0] i, input int n);
    return {i, 8'(n * 37 + 5)} ^ 16'hA5C3;
  endfunction

  assign busDin = pat(curIdx, readNum);

  always @(negedge clk) begin
    if (rstN) begin
      logic on;
      on = !busRdN || !busWrN;
      if (on != !busCsN) csErr++;
      if (!busRdN && busOe) oeErr++;
      if (!busWrN && !busOe) oeErr++;
      if (on && !prevOn && evCount < 8) begin
        evKind[evCount]  = busAddrSel ? 0 : (!busWrN ? 1 : 2);
        evVal[evCount]   = busOe ? busDout : 16'h0;
        evGap[evCount]   = idleRun;
        evWidth[evCount] = 0;
        evCount++;
      end
      if (on) begin
        onRun++;
        idleRun = 0;
      end else begin
        if (prevOn && evCount > 0) begin
          evWidth[evCount-1] = onRun;
          if (evKind[evCount-1] == 2) readNum++;
        end
        onRun = 0;
        idleRun++;
      end
      prevOn = on;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic access(input bit w, input bit s32, input logic [7:0] idx,
                        input logic [31:0] wd, input bit poke);
    int k;
    int lat;
    int nData;
    logic [15:0] expAddr;
    evCount = 0;
    readNum = 0;
    curIdx  = idx;
    @(negedge clk);
    req = 1'b1; we = w; size32 = s32; index = idx; wdata = wd;
    k = 0;
    lat = 1 + 2 * SC + AGAP + DGAP + (s32 ? DGAP + SC : 0);
    while (1) begin
      @(negedge clk);
      k++;
      if (k == 1) begin
        req = 1'b0;
        chk(busy == 1'b1, "R10 busy after accept", busy, 1);
      end
      if (poke && k == 8) begin
        req = 1'b1; index = ~idx; we = ~w;
      end
      if (poke && k == 10) req = 1'b0;
      if (ack || k > 400) break;
    end
    req = 1'b0;
    chk(k == lat, "R11 latency", k, lat);
    if (!w) begin
      logic [31:0] expR;
      expR = s32 ? {pat(idx, 1), pat(idx, 0)} : {16'h0, pat(idx, 0)};
      chk(rdata == expR, s32 ? "R4 read assembly" : "R5 read 16", rdata, expR);
    end
    @(negedge clk);
    chk(busy == 1'b0 && ack == 1'b0, "R10 release after ack", {busy, ack}, 0);
    nData = s32 ? 2 : 1;
    chk(evCount == nData + 1, "R10 R5 cycle count", evCount, nData + 1);
    expAddr = {8'h00, idx | (w ? 8'h80 : 8'h00)};
    chk(evKind[0] == 0 && evVal[0] == expAddr, "R2 index word", evVal[0], expAddr);
    for (int e = 0; e < evCount && e < 3; e++)
      chk(evWidth[e] == SC, "R8 strobe width", evWidth[e], SC);
    if (evCount >= 2) begin
      chk(evKind[1] == (w ? 1 : 2), "R9 data direction", evKind[1], w ? 1 : 2);
      chk(evGap[1] == AGAP, "R6 index gap", evGap[1], AGAP);
      if (w) chk(evVal[1] == wd[15:0], s32 ? "R3 low half" : "R5 write 16", evVal[1], wd[15:0]);
    end
    if (s32 && evCount >= 3) begin
      chk(evGap[2] == DGAP, "R7 data gap", evGap[2], DGAP);
      if (w) chk(evVal[2] == wd[31:16], "R3 high half", evVal[2], wd[31:16]);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    chk(busCsN && busRdN && busWrN && !busOe && !busy && !ack, "R1 reset state",
        {busCsN, busRdN, busWrN, busOe, busy, ack}, 6'b111000);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(busCsN && busRdN && busWrN && !busOe && !busy, "R1 idle after reset",
        {busCsN, busRdN, busWrN, busOe, busy}, 5'b11100);
    for (int m = 0; m < 4; m++) begin
      for (int i = 0; i < 256; i += 17) begin
        logic [31:0] wd;
        wd = {8'(i * 3), 8'(m + 11), 8'(i ^ 8'h5A), 8'(255 - i)};
        access(m[0], m[1], 8'(i), wd, (i % 34) == 0);
      end
      access(m[0], m[1], 8'h7F, 32'hDEAD_BEEF, 1'b0);
      access(m[0], m[1], 8'h80, 32'h1234_8001, 1'b1);
    end
    chk(oeErr == 0, "R9 output enable", oeErr, 0);
    chk(csErr == 0, "R8 chip select", csErr, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule